// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the scheduling controller for a pipeline that issues instructions in program order and lets them finish out of order. Decoded instructions arrive over a valid/ready handshake. Each carries an operation class, a destination register and two source registers. The controller places each instruction in a functional unit of the right class and records, for every unit, which registers it reads and which units must produce those registers first. A result-status table records which unit will write each register. No data values pass through the block: each execution unit is modelled as a countdown timer whose length depends on the operation class.

Every instruction passes through four gated steps: issue, operand read, execution and result write. Each step can stall for its own reason. Issue stalls on a missing unit or on a pending writer of the same destination. Operand read waits for the producers and for a free read port. Execution lasts a fixed number of cycles. Result write waits until no unit still needs the old register value. The block reports each step as a per-unit pulse in the cycle whose closing clock edge carries it out.

Top module: `sb_ctrl`

## Requirements
- R1: After reset no unit is busy and all registers are free. `in_ready` is high for any class, and `issue_o`, `read_o`, `done_o` and `write_o` are all zero until an instruction is accepted.
- R2: Class codes on `in_op`: 0 load, 1 integer ALU, 2 floating add, 3 multiply, 4 divide. Codes 5 to 7 act as integer ALU. Units 0 and 1 serve load and ALU, units 2 and 3 serve add, unit 4 serves multiply and unit 5 serves divide. An accepted instruction takes the lowest-numbered free unit of its class, and `issue_o` marks that unit alone.
- R3: Issue is in order. `in_ready` is low whenever every unit of the presented class is busy, even when units of other classes are idle.
- R4: `in_ready` is low while the presented destination register has a pending writer.
- R5: A unit reads its operands in the cycle after both operands become available. An operand is available either at issue, when no unit is pending on the register, or at the edge where its producer writes. A producer that writes in the same cycle the consumer issues counts as already written.
- R6: Two units that share any source register never read in the same cycle. The lower-numbered unit reads first and the other follows one cycle later.
- R7: Counted from the read cycle, `done_o` pulses L cycles later. L is 4 for load, 3 for ALU, 6 for add, 11 for multiply and LAT_FDIV for divide, and every latency is at least 2. The write can come at the earliest in the following cycle.
- R8: A finished unit does not write while another busy unit has a source equal to its destination with that operand marked ready but not yet read.
- R9: At most one unit writes per cycle. Among eligible finished units the lowest-numbered one wins.
- R10: A write frees the unit and its destination register at that edge. Units waiting on the writer become ready at the same edge.
- R11: The divide latency is the parameter LAT_FDIV, which defaults to 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | The presented instruction is accepted at this edge |
| in_op | input | 3 | Operation class |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src1 | input | $clog2(NREG) | First source register |
| in_src2 | input | $clog2(NREG) | Second source register |
| issue_o | output | 6 | Unit receiving the instruction at this edge |
| read_o | output | 6 | Units reading operands at this edge |
| done_o | output | 6 | Units in their last execution cycle |
| write_o | output | 6 | Unit writing its result at this edge |

## Verification
The hardest situations to reach are a write held back by a reader that has only one of its two operands, two units released by the same write that then compete for a read port, and a consumer that issues in the very cycle its producer writes. Directed sequences build each of these. A long divide supplies the missing operand of an add whose other source is the destination of a short ALU operation. A multiply feeds two adds that share its result. A dependent add is presented exactly six cycles after a load is accepted. A long random stream over eight registers then piles up all of these cases, and every output is compared on every cycle against a behavioural model.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int N_INT = 2;
    localparam int N_ADD = 2;
    localparam int N_MUL = 1;
    localparam int N_DIV = 1;
    localparam int NFU   = N_INT + N_ADD + N_MUL + N_DIV;
    localparam int UW    = $clog2(NFU);

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0, OP_ALU = 3'd1, OP_FADD = 3'd2, OP_FMUL = 3'd3, OP_FDIV = 3'd4
    } op_e;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_EXEC, ST_DONE} stage_e;

    function automatic int class_base(logic [2:0] op);
        case (op)
            OP_FADD: return N_INT;
            OP_FMUL: return N_INT + N_ADD;
            OP_FDIV: return N_INT + N_ADD + N_MUL;
            default: return 0;
        endcase
    endfunction

    function automatic int class_size(logic [2:0] op);
        case (op)
            OP_FADD: return N_ADD;
            OP_FMUL: return N_MUL;
            OP_FDIV: return N_DIV;
            default: return N_INT;
        endcase
    endfunction
endpackage

// File: rtl/sb_issue_pick.sv
module sb_issue_pick
    import sb_pkg::*;
(
    input  logic [NFU-1:0] busy,
    input  logic [2:0]     op,
    output logic           found,
    output logic [UW-1:0]  idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int u = NFU - 1; u >= 0; u--) begin
            if (u >= class_base(op) && u < class_base(op) + class_size(op) && !busy[u]) begin
                found = 1'b1;
                idx   = UW'(u);
            end
        end
    end
endmodule

// File: rtl/sb_read_arb.sv
module sb_read_arb
    import sb_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [NFU-1:0] req,
    input  logic [RW-1:0]  fj [NFU],
    input  logic [RW-1:0]  fk [NFU],
    output logic [NFU-1:0] gnt
);
    logic clash;

    always_comb begin
        gnt   = '0;
        clash = 1'b0;
        for (int u = 0; u < NFU; u++) begin
            clash = 1'b0;
            for (int g = 0; g < u; g++) begin
                if (gnt[g] && (fj[g] == fj[u] || fj[g] == fk[u] ||
                               fk[g] == fj[u] || fk[g] == fk[u]))
                    clash = 1'b1;
            end
            gnt[u] = req[u] && !clash;
        end
    end
endmodule

// File: rtl/sb_write_arb.sv
module sb_write_arb
    import sb_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [NFU-1:0] fin,
    input  logic [NFU-1:0] busy,
    input  logic [NFU-1:0] rj,
    input  logic [NFU-1:0] rk,
    input  logic [RW-1:0]  fi [NFU],
    input  logic [RW-1:0]  fj [NFU],
    input  logic [RW-1:0]  fk [NFU],
    output logic [NFU-1:0] gnt,
    output logic           any,
    output logic [UW-1:0]  idx
);
    logic [NFU-1:0] elig;

    always_comb begin
        for (int f = 0; f < NFU; f++) begin
            elig[f] = fin[f];
            for (int u = 0; u < NFU; u++) begin
                if (u != f && busy[u] &&
                    ((rj[u] && fj[u] == fi[f]) || (rk[u] && fk[u] == fi[f])))
                    elig[f] = 1'b0;
            end
        end
        gnt = elig & (~elig + 1'b1);
        any = |elig;
        idx = '0;
        for (int f = NFU - 1; f >= 0; f--)
            if (elig[f]) idx = UW'(f);
    end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int LAT_LOAD = 4,
    parameter int LAT_ALU  = 3,
    parameter int LAT_FADD = 6,
    parameter int LAT_FMUL = 11,
    parameter int LAT_FDIV = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [2:0]              in_op,
    input  logic [$clog2(NREG)-1:0] in_dst,
    input  logic [$clog2(NREG)-1:0] in_src1,
    input  logic [$clog2(NREG)-1:0] in_src2,
    output logic [NFU-1:0]          issue_o,
    output logic [NFU-1:0]          read_o,
    output logic [NFU-1:0]          done_o,
    output logic [NFU-1:0]          write_o
);
    localparam int RW     = $clog2(NREG);
    localparam int LATMAX = (LAT_FDIV > LAT_FMUL) ? LAT_FDIV : LAT_FMUL;
    localparam int CW     = $clog2(LATMAX + 1);

    typedef struct packed {
        logic          busy;
        logic [2:0]    op;
        logic [RW-1:0] fi;
        logic [RW-1:0] fj;
        logic [RW-1:0] fk;
        logic          qjv;
        logic [UW-1:0] qj;
        logic          qkv;
        logic [UW-1:0] qk;
        logic          rj;
        logic          rk;
        stage_e        st;
        logic [CW-1:0] cnt;
    } unit_t;

    typedef struct packed {
        unit_t [NFU-1:0]           fu;
        logic  [NREG-1:0]          rsv;
        logic  [NREG-1:0][UW-1:0]  rsu;
    } state_t;

    state_t s_d, s_q;

    function automatic logic [CW-1:0] lat_of(logic [2:0] op);
        case (op)
            OP_LOAD: return CW'(LAT_LOAD);
            OP_FADD: return CW'(LAT_FADD);
            OP_FMUL: return CW'(LAT_FMUL);
            OP_FDIV: return CW'(LAT_FDIV);
            default: return CW'(LAT_ALU);
        endcase
    endfunction

    logic [NFU-1:0] busy_v, rj_v, rk_v, rdreq_v, fin_v, wr_gnt, rd_gnt;
    logic [RW-1:0]  fi_a [NFU];
    logic [RW-1:0]  fj_a [NFU];
    logic [RW-1:0]  fk_a [NFU];
    logic           free_ok, wr_any, fire;
    logic [UW-1:0]  free_idx, wr_idx;

    for (genvar u = 0; u < NFU; u++) begin : g_unit_view
        assign busy_v[u]  = s_q.fu[u].busy;
        assign rj_v[u]    = s_q.fu[u].rj;
        assign rk_v[u]    = s_q.fu[u].rk;
        assign rdreq_v[u] = s_q.fu[u].busy && s_q.fu[u].rj && s_q.fu[u].rk;
        assign fin_v[u]   = s_q.fu[u].st == ST_DONE;
        assign fi_a[u]    = s_q.fu[u].fi;
        assign fj_a[u]    = s_q.fu[u].fj;
        assign fk_a[u]    = s_q.fu[u].fk;
        assign done_o[u]  = s_q.fu[u].st == ST_EXEC && s_q.fu[u].cnt == CW'(1);
    end

    sb_issue_pick pick_i (
        .busy (busy_v),
        .op   (in_op),
        .found(free_ok),
        .idx  (free_idx)
    );

    sb_read_arb #(.RW(RW)) rd_arb_i (
        .req(rdreq_v),
        .fj (fj_a),
        .fk (fk_a),
        .gnt(rd_gnt)
    );

    sb_write_arb #(.RW(RW)) wr_arb_i (
        .fin (fin_v),
        .busy(busy_v),
        .rj  (rj_v),
        .rk  (rk_v),
        .fi  (fi_a),
        .fj  (fj_a),
        .fk  (fk_a),
        .gnt (wr_gnt),
        .any (wr_any),
        .idx (wr_idx)
    );

    assign in_ready = rst_n && free_ok && !s_q.rsv[in_dst];
    assign fire     = in_valid && in_ready;
    assign issue_o  = fire ? (NFU'(1) << free_idx) : '0;
    assign read_o   = rd_gnt;
    assign write_o  = wr_gnt;

    always_comb begin
        s_d = s_q;
        for (int u = 0; u < NFU; u++) begin
            if (rd_gnt[u]) begin
                s_d.fu[u].rj  = 1'b0;
                s_d.fu[u].rk  = 1'b0;
                s_d.fu[u].st  = ST_EXEC;
                s_d.fu[u].cnt = lat_of(s_q.fu[u].op);
            end else if (s_q.fu[u].st == ST_EXEC) begin
                s_d.fu[u].cnt = s_q.fu[u].cnt - 1'b1;
                if (s_q.fu[u].cnt == CW'(1)) s_d.fu[u].st = ST_DONE;
            end
            if (wr_any && s_q.fu[u].qjv && s_q.fu[u].qj == wr_idx) begin
                s_d.fu[u].qjv = 1'b0;
                s_d.fu[u].rj  = 1'b1;
            end
            if (wr_any && s_q.fu[u].qkv && s_q.fu[u].qk == wr_idx) begin
                s_d.fu[u].qkv = 1'b0;
                s_d.fu[u].rk  = 1'b1;
            end
            if (wr_gnt[u]) begin
                s_d.fu[u]                  = '0;
                s_d.rsv[s_q.fu[u].fi]      = 1'b0;
            end
        end
        if (fire) begin
            s_d.fu[free_idx].busy = 1'b1;
            s_d.fu[free_idx].op   = in_op;
            s_d.fu[free_idx].fi   = in_dst;
            s_d.fu[free_idx].fj   = in_src1;
            s_d.fu[free_idx].fk   = in_src2;
            s_d.fu[free_idx].st   = ST_WAIT;
            s_d.fu[free_idx].cnt  = '0;
            s_d.fu[free_idx].qjv  = s_q.rsv[in_src1] && !(wr_any && s_q.rsu[in_src1] == wr_idx);
            s_d.fu[free_idx].qj   = s_q.rsu[in_src1];
            s_d.fu[free_idx].rj   = !s_d.fu[free_idx].qjv;
            s_d.fu[free_idx].qkv  = s_q.rsv[in_src2] && !(wr_any && s_q.rsu[in_src2] == wr_idx);
            s_d.fu[free_idx].qk   = s_q.rsu[in_src2];
            s_d.fu[free_idx].rk   = !s_d.fu[free_idx].qkv;
            s_d.rsv[in_dst]       = 1'b1;
            s_d.rsu[in_dst]       = free_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk
    import sb_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [NFU-1:0] issue_o,
    input logic [NFU-1:0] read_o,
    input logic [NFU-1:0] done_o,
    input logic [NFU-1:0] write_o
);
    a_r2_issue_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_o));

    a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(write_o));

    a_r3_issue_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o != '0) |-> (in_valid && in_ready));

    for (genvar u = 0; u < NFU; u++) begin : g_unit_chk
        a_r5_read_once: assert property (@(posedge clk) disable iff (!rst_n)
            read_o[u] |=> !read_o[u]);

        a_r7_no_instant_done: assert property (@(posedge clk) disable iff (!rst_n)
            read_o[u] |=> !done_o[u]);

        a_r7_done_not_write: assert property (@(posedge clk) disable iff (!rst_n)
            !(done_o[u] && write_o[u]));

        a_r10_unit_freed: assert property (@(posedge clk) disable iff (!rst_n)
            write_o[u] |=> (!write_o[u] && !read_o[u]));
    end
endmodule

bind sb_ctrl sb_ctrl_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .issue_o (issue_o),
    .read_o  (read_o),
    .done_o  (done_o),
    .write_o (write_o)
);

// File: tb/sb_ctrl_tb_top.sv
module sb_ctrl_tb_top;
    localparam int NU = 6;
    localparam int NR = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [2:0] in_op = '0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [NU-1:0] issue_o, read_o, done_o, write_o;

    always #5 clk = ~clk;

    sb_ctrl #(.NREG(NR), .LAT_FDIV(40)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .issue_o(issue_o), .read_o(read_o), .done_o(done_o), .write_o(write_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int m_busy[NU], m_op[NU], m_fi[NU], m_fj[NU], m_fk[NU];
    int m_qj[NU], m_qk[NU], m_rj[NU], m_rk[NU], m_st[NU], m_cnt[NU];
    int m_rs[NR];
    int t_iss[NU], t_rd[NU], t_dn[NU], t_wr[NU];

    function automatic int base_of(int op);
        return (op == 2) ? 2 : (op == 3) ? 4 : (op == 4) ? 5 : 0;
    endfunction
    function automatic int size_of(int op);
        return (op == 3 || op == 4) ? 1 : 2;
    endfunction
    function automatic int lat(int op);
        return (op == 0) ? 4 : (op == 2) ? 6 : (op == 3) ? 11 : (op == 4) ? 40 : 3;
    endfunction
    function automatic bit war_held(int f);
        for (int u = 0; u < NU; u++)
            if (u != f && m_busy[u] != 0 &&
                ((m_rj[u] != 0 && m_fj[u] == m_fi[f]) || (m_rk[u] != 0 && m_fk[u] == m_fi[f])))
                return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        for (int u = 0; u < NU; u++) begin
            m_busy[u] = 0; m_st[u] = 0; m_rj[u] = 0; m_rk[u] = 0;
            m_qj[u] = -1; m_qk[u] = -1; m_cnt[u] = 0;
            t_iss[u] = -1; t_rd[u] = -1; t_dn[u] = -1; t_wr[u] = -1;
        end
        for (int r = 0; r < NR; r++) m_rs[r] = -1;
    endtask

    task automatic tick(input bit v, input int op, input int d, input int a, input int b,
                        output bit acc);
        int wr, fr;
        bit gr[NU];
        bit rdy, clash;
        logic [NU-1:0] e_is, e_rd, e_dn, e_wr;
        in_valid = v; in_op = op[2:0]; in_dst = d[4:0]; in_src1 = a[4:0]; in_src2 = b[4:0];
        wr = -1;
        for (int f = 0; f < NU; f++)
            if (wr < 0 && m_st[f] == 3 && !war_held(f)) wr = f;
        for (int u = 0; u < NU; u++) begin
            clash = 1'b0;
            for (int g = 0; g < u; g++)
                if (gr[g] && (m_fj[g] == m_fj[u] || m_fj[g] == m_fk[u] ||
                              m_fk[g] == m_fj[u] || m_fk[g] == m_fk[u])) clash = 1'b1;
            gr[u] = m_busy[u] != 0 && m_rj[u] != 0 && m_rk[u] != 0 && !clash;
        end
        fr = -1;
        for (int u = base_of(op) + size_of(op) - 1; u >= base_of(op); u--)
            if (m_busy[u] == 0) fr = u;
        rdy = fr >= 0 && m_rs[d] < 0;
        acc = v && rdy;
        e_is = '0; e_rd = '0; e_dn = '0; e_wr = '0;
        for (int u = 0; u < NU; u++) begin
            e_rd[u] = gr[u];
            e_dn[u] = m_st[u] == 2 && m_cnt[u] == 1;
            e_wr[u] = wr == u;
            e_is[u] = acc && fr == u;
        end
        #4;
        check(in_ready == rdy, "R3/R4 in_ready", int'(in_ready), int'(rdy));
        check(issue_o == e_is, "R2 issue_o", int'(issue_o), int'(e_is));
        check(read_o == e_rd, "R5/R6 read_o", int'(read_o), int'(e_rd));
        check(done_o == e_dn, "R7 done_o", int'(done_o), int'(e_dn));
        check(write_o == e_wr, "R8/R9 write_o", int'(write_o), int'(e_wr));
        for (int u = 0; u < NU; u++) begin
            if (issue_o[u]) t_iss[u] = cyc;
            if (read_o[u])  t_rd[u]  = cyc;
            if (done_o[u])  t_dn[u]  = cyc;
            if (write_o[u]) t_wr[u]  = cyc;
        end
        for (int u = 0; u < NU; u++) begin
            if (gr[u]) begin
                m_rj[u] = 0; m_rk[u] = 0; m_st[u] = 2; m_cnt[u] = lat(m_op[u]);
            end else if (m_st[u] == 2) begin
                m_cnt[u]--;
                if (m_cnt[u] == 0) m_st[u] = 3;
            end
            if (wr >= 0 && m_qj[u] == wr) begin m_qj[u] = -1; m_rj[u] = 1; end
            if (wr >= 0 && m_qk[u] == wr) begin m_qk[u] = -1; m_rk[u] = 1; end
        end
        if (wr >= 0) begin
            m_rs[m_fi[wr]] = -1;
            m_busy[wr] = 0; m_st[wr] = 0;
        end
        if (acc) begin
            m_busy[fr] = 1; m_op[fr] = op; m_fi[fr] = d; m_fj[fr] = a; m_fk[fr] = b;
            m_st[fr] = 1; m_qj[fr] = m_rs[a]; m_qk[fr] = m_rs[b];
            m_rj[fr] = (m_rs[a] < 0) ? 1 : 0;
            m_rk[fr] = (m_rs[b] < 0) ? 1 : 0;
            m_rs[d] = fr;
        end
        @(posedge clk); #1;
        cyc++;
    endtask

    task automatic send(input int op, input int d, input int a, input int b);
        bit acc = 1'b0;
        for (int k = 0; k < 2000 && !acc; k++) tick(1'b1, op, d, a, b, acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int k = 0; k < n; k++) tick(1'b0, 0, 0, 0, 0, acc);
    endtask

    task automatic drain();
        bit any;
        for (int k = 0; k < 3000; k++) begin
            any = 1'b0;
            for (int u = 0; u < NU; u++) if (m_busy[u] != 0) any = 1'b1;
            if (!any) break;
            idle(1);
        end
    endtask

    task automatic probe(input int op, input int d, input string req);
        int u;
        u = base_of(op);
        drain();
        send(op, d, d + 1, d + 2);
        drain();
        check(t_rd[u] - t_iss[u] == 1, "R5 read one cycle after issue", t_rd[u] - t_iss[u], 1);
        check(t_dn[u] - t_rd[u] == lat(op), req, t_dn[u] - t_rd[u], lat(op));
        check(t_wr[u] - t_dn[u] == 1, "R7 write after done", t_wr[u] - t_dn[u], 1);
    endtask

    initial begin
        bit acc;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        in_valid = 1'b1; in_op = 3'd1; in_dst = 5'd3;
        #3;
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check((issue_o | read_o | done_o | write_o) == '0 || in_valid,
              "R1 idle pulses", int'(read_o | done_o | write_o), 0);
        check((read_o | done_o | write_o) == '0, "R1 no activity", int'(read_o | done_o | write_o), 0);
        in_valid = 1'b0;
        @(posedge clk); #1;

        probe(0, 1, "R7 load latency");
        probe(1, 4, "R7 ALU latency");
        probe(2, 7, "R7 add latency");
        probe(3, 10, "R7 multiply latency");
        probe(4, 13, "R11 divide latency");

        drain();
        send(3, 1, 2, 3);
        tick(1'b1, 3, 4, 5, 6, acc);
        check(acc == 1'b0 && in_ready == 1'b0, "R3 multiply stalls with int idle", int'(acc), 0);
        drain();
        send(2, 5, 1, 2);
        tick(1'b1, 1, 5, 3, 4, acc);
        check(acc == 1'b0, "R4 pending writer stalls issue", int'(acc), 0);
        drain();

        send(3, 1, 2, 3);
        send(2, 10, 1, 4);
        send(2, 11, 1, 5);
        drain();
        check(t_rd[2] == t_wr[4] + 1, "R10 waiter reads after write", t_rd[2], t_wr[4] + 1);
        check(t_rd[3] == t_rd[2] + 1, "R6 shared source read delayed", t_rd[3], t_rd[2] + 1);

        send(4, 7, 2, 3);
        send(2, 6, 7, 8);
        send(1, 8, 9, 9);
        drain();
        check(t_wr[0] == t_rd[2] + 1, "R8 write held until reader reads", t_wr[0], t_rd[2] + 1);

        send(0, 12, 13, 13);
        send(1, 14, 15, 15);
        drain();
        check(t_dn[0] == t_dn[1], "R9 both finish together", t_dn[1], t_dn[0]);
        check(t_wr[1] == t_wr[0] + 1, "R9 lower unit writes first", t_wr[1], t_wr[0] + 1);

        send(0, 20, 21, 21);
        idle(5);
        send(2, 22, 20, 23);
        drain();
        check(t_iss[2] == t_wr[0], "R5 issue in producer write cycle", t_iss[2], t_wr[0]);
        check(t_rd[2] == t_wr[0] + 1, "R5 same-cycle producer counts as written", t_rd[2], t_wr[0] + 1);

        for (int i = 0; i < 500; i++) begin
            if ($urandom_range(9) < 3) idle(1);
            else send(int'($urandom_range(4)), int'($urandom_range(7)),
                      int'($urandom_range(7)), int'($urandom_range(7)));
        end
        drain();
        in_valid = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (R1..R11 run incomplete) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule